// File: doc/BRIEF.md
# UART Modem Control and Loop-Back Unit

This block holds the 8-bit modem control register of one UART channel. Software writes it over a simple parallel bus. The register drives the channel's active-low handshake pins and the general-purpose output pin. It also sets the output enable of the interrupt pin driver. Beyond the pins, it hands three settings to neighbouring logic: a choice between divide-by-1 and divide-by-4 of the input clock, an access gate for the trigger-control and trigger-level registers, and an enable for resuming transmission on any received character.

The three uppermost register bits are protected. A write changes them only while the enhanced-feature unlock input is high. The five lower bits change on every write.

Setting the loop-back bit closes the channel on itself:
- The core's serial output returns to the core's serial input.
- The external transmit pin rests at mark.
- RTS, DTR and OP sit inactive.
- The four lower control bits stand in for the external modem inputs in the upper status nibble.

Outside loop-back, that nibble shows the carrier-detect, ring, data-set-ready and clear-to-send inputs. Each one is inverted and passed through a two-flop synchronizer.

When automatic RTS is enabled, the RTS pin follows the flow-control engine's request instead of the register bit.

Top module: `modem_ctl_top`

## Requirements
- R1: On a clock edge with `wr_en` high, bits 4:0 take `wr_data[4:0]`, and bits 7:5 take `wr_data[7:5]` only if `unlock` is 1 (otherwise they keep their value). `rd_data` always returns all eight stored bits.
- R2: `clk_div4_sel` equals control bit 7 (0 = divide-by-1, 1 = divide-by-4).
- R3: `trig_access_en` equals control bit 6 and `xon_any_en` equals control bit 5.
- R4: With control bit 4 set, `loop_active` is 1, `core_rx` equals `core_tx` and `tx_pin` is 1. With bit 4 clear, `core_rx` equals `rx_pin` and `tx_pin` equals `core_tx`.
- R5: In loop-back, `msr_hi` = {bit 3, bit 2, bit 0, bit 1} of the control register. `msr_hi[3:0]` are status bits 7:4 (CD, RI, DSR, CTS).
- R6: Outside loop-back, `msr_hi` = {~cd_n, ~ri_n, ~dsr_n, ~cts_n}, each delayed by two clock edges.
- R7: `irq_oe` equals control bit 3. Outside loop-back, `op_n` is the inverse of bit 3.
- R8: Outside loop-back and with `auto_rts_en` low, `rts_n` = ~bit 1 and `dtr_n` = ~bit 0.
- R9: Outside loop-back with `auto_rts_en` high, `rts_n` = ~`flow_rts_req`.
- R10: In loop-back, `rts_n`, `dtr_n` and `op_n` are held at 1.
- R11: A clock edge with `rst_n` low clears the register to 0x00 and sets every synchronizer flop to the inactive (high) pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| unlock | input | 1 | Enhanced-feature enable, gates bits 7:5 |
| rd_data | output | 8 | Stored register value |
| auto_rts_en | input | 1 | Hardware flow control owns RTS |
| flow_rts_req | input | 1 | Flow-control engine RTS request, active high |
| cd_n | input | 1 | Carrier detect pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dsr_n | input | 1 | Data set ready pin, active low |
| cts_n | input | 1 | Clear to send pin, active low |
| core_tx | input | 1 | Serial output of the UART core |
| rx_pin | input | 1 | External serial input pin |
| tx_pin | output | 1 | External serial output pin |
| core_rx | output | 1 | Serial input to the UART core |
| rts_n | output | 1 | Request to send pin, active low |
| dtr_n | output | 1 | Data terminal ready pin, active low |
| op_n | output | 1 | General-purpose output pin, active low |
| irq_oe | output | 1 | Interrupt pin driver enable |
| clk_div4_sel | output | 1 | Input clock divide-by-4 select |
| trig_access_en | output | 1 | Trigger register access enable |
| xon_any_en | output | 1 | Xon-Any enable |
| loop_active | output | 1 | Loop-back mode active |
| msr_hi | output | 4 | Modem status bits 7:4 |

## Verification
The properties assume every input is steady around the clock edge. They also assume that `unlock` and `wr_en` are valid in the same cycle as `wr_data`, so the protection check compares one edge against the next. The bench changes every input only on the falling clock edge. It draws `unlock`, the write data, the flow-control inputs and the modem pins from `$urandom` with a fixed seed. It also inserts occasional mid-run resets and directed writes of 0xFF and 0x00, with and without unlock, so the protected-bit cases occur for certain.

// File: rtl/modem_ctl_pkg.sv
// Shared bit positions and widths of the modem control unit.
// Assumes an 8-bit control register with a protected upper field.
package modem_ctl_pkg;
    localparam int CTL_W     = 8;
    localparam int PROT_LSB  = 5;
    localparam int STAT_W    = 4;
    localparam int SYNC_STG  = 2;
    localparam int B_DTR     = 0;
    localparam int B_RTS     = 1;
    localparam int B_AUX     = 2;
    localparam int B_OUT     = 3;
    localparam int B_LOOP    = 4;
    localparam int B_XANY    = 5;
    localparam int B_TRIG    = 6;
    localparam int B_CDIV    = 7;

    // Upper modem status nibble, MSB first: CD, RI, DSR, CTS.
    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
    } mstat_t;
endpackage

// File: rtl/modem_ctl_reg.sv
// Control register with a write-protected upper field.
// Assumes wr_data and unlock are valid together with wr_en.
module modem_ctl_reg #(
    parameter int W    = 8,
    parameter int PLSB = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         unlock,
    output logic [W-1:0] q
);
    localparam int PW = W - PLSB;

    logic [PW-1:0]   prot_q;
    logic [PLSB-1:0] free_q;

    // Store the protected field only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prot_q <= '0;
        else if (wr_en && unlock)
            prot_q <= wr_data[W-1:PLSB];
    end

    // Store the free field on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            free_q <= '0;
        else if (wr_en)
            free_q <= wr_data[PLSB-1:0];
    end

    assign q = {prot_q, free_q};
endmodule

// File: rtl/modem_sync.sv
// Multi-stage synchronizer for the active-low modem inputs.
// Assumes asynchronous inputs; reset loads the inactive pin level.
module modem_sync #(
    parameter int          W      = 4,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_V = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_V;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Shift one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RST_V;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/modem_loop_mux.sv
// Pin and status steering between normal and loop-back operation.
// Assumes ctl holds the five lower control bits; purely combinational.
module modem_loop_mux
    import modem_ctl_pkg::*;
(
    input  logic [PROT_LSB-1:0] ctl,
    input  mstat_t              pins_sync_n,
    input  logic                auto_rts_en,
    input  logic                flow_rts_req,
    input  logic                core_tx,
    input  logic                rx_pin,
    output logic                tx_pin,
    output logic                core_rx,
    output logic                rts_n,
    output logic                dtr_n,
    output logic                op_n,
    output mstat_t              stat
);
    logic loop;
    logic rts_want;

    assign loop = ctl[B_LOOP];

    // Pick the RTS source: flow-control engine or register bit.
    always_comb begin
        if (auto_rts_en) rts_want = flow_rts_req;
        else             rts_want = ctl[B_RTS];
    end

    // Drive external pins, parked inactive in loop-back.
    always_comb begin
        if (loop) begin
            tx_pin = 1'b1;
            rts_n  = 1'b1;
            dtr_n  = 1'b1;
            op_n   = 1'b1;
        end else begin
            tx_pin = core_tx;
            rts_n  = ~rts_want;
            dtr_n  = ~ctl[B_DTR];
            op_n   = ~ctl[B_OUT];
        end
    end

    // Route the serial return path to the core.
    always_comb begin
        core_rx = loop ? core_tx : rx_pin;
    end

    // Select the status nibble source.
    always_comb begin
        if (loop) begin
            stat.cd  = ctl[B_OUT];
            stat.ri  = ctl[B_AUX];
            stat.dsr = ctl[B_DTR];
            stat.cts = ctl[B_RTS];
        end else begin
            stat.cd  = ~pins_sync_n.cd;
            stat.ri  = ~pins_sync_n.ri;
            stat.dsr = ~pins_sync_n.dsr;
            stat.cts = ~pins_sync_n.cts;
        end
    end
endmodule

// File: rtl/modem_ctl_top.sv
// Modem control unit for one UART channel: register, synchronizers and loop-back steering.
// Assumes all bus inputs are synchronous to clk; modem pins may be asynchronous.
module modem_ctl_top
    import modem_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  wr_data,
    input  logic              unlock,
    output logic [CTL_W-1:0]  rd_data,
    input  logic              auto_rts_en,
    input  logic              flow_rts_req,
    input  logic              cd_n,
    input  logic              ri_n,
    input  logic              dsr_n,
    input  logic              cts_n,
    input  logic              core_tx,
    input  logic              rx_pin,
    output logic              tx_pin,
    output logic              core_rx,
    output logic              rts_n,
    output logic              dtr_n,
    output logic              op_n,
    output logic              irq_oe,
    output logic              clk_div4_sel,
    output logic              trig_access_en,
    output logic              xon_any_en,
    output logic              loop_active,
    output logic [STAT_W-1:0] msr_hi
);
    logic [CTL_W-1:0] ctl_q;
    mstat_t           pins_raw;
    mstat_t           pins_sync;
    mstat_t           stat;

    assign pins_raw = '{cd: cd_n, ri: ri_n, dsr: dsr_n, cts: cts_n};

    modem_ctl_reg #(.W(CTL_W), .PLSB(PROT_LSB)) i_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .unlock  (unlock),
        .q       (ctl_q)
    );

    modem_sync #(.W(STAT_W), .STAGES(SYNC_STG), .RST_V('1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_sync)
    );

    modem_loop_mux i_mux (
        .ctl          (ctl_q[PROT_LSB-1:0]),
        .pins_sync_n  (pins_sync),
        .auto_rts_en  (auto_rts_en),
        .flow_rts_req (flow_rts_req),
        .core_tx      (core_tx),
        .rx_pin       (rx_pin),
        .tx_pin       (tx_pin),
        .core_rx      (core_rx),
        .rts_n        (rts_n),
        .dtr_n        (dtr_n),
        .op_n         (op_n),
        .stat         (stat)
    );

    assign rd_data        = ctl_q;
    assign msr_hi         = stat;
    assign irq_oe         = ctl_q[B_OUT];
    assign clk_div4_sel   = ctl_q[B_CDIV];
    assign trig_access_en = ctl_q[B_TRIG];
    assign xon_any_en     = ctl_q[B_XANY];
    assign loop_active    = ctl_q[B_LOOP];
endmodule

// File: rtl/modem_ctl_chk.sv
// Property checker for modem_ctl_top, attached by bind.
// Assumes inputs change away from the rising clock edge.
module modem_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       unlock,
    input logic [7:0] rd_data,
    input logic       auto_rts_en,
    input logic       flow_rts_req,
    input logic       core_tx,
    input logic       tx_pin,
    input logic       core_rx,
    input logic       rts_n,
    input logic       dtr_n,
    input logic       op_n,
    input logic       irq_oe,
    input logic       loop_active,
    input logic [3:0] msr_hi
);
    // R1: the protected field holds through a locked write
    assert_prot_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlock) |=> rd_data[7:5] == $past(rd_data[7:5]));

    // R1: the free field always takes the written value
    assert_free_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[4:0] == $past(wr_data[4:0]));

    // R4: the serial path closes on itself in loop-back
    assert_loop_serial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        loop_active |-> (core_rx == core_tx) && tx_pin);

    // R5: status nibble mirrors the control bits in loop-back
    assert_loop_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        loop_active |-> msr_hi == {rd_data[3], rd_data[2], rd_data[0], rd_data[1]});

    // R7: OP pin and interrupt enable are complementary outside loop-back
    assert_op_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_active |-> op_n == !irq_oe);

    // R9: automatic RTS follows the flow-control request
    assert_auto_rts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_active && auto_rts_en) |-> rts_n == !flow_rts_req);

    // R10: handshake pins parked inactive in loop-back
    assert_loop_park_R10: assert property (@(posedge clk) disable iff (!rst_n)
        loop_active |-> rts_n && dtr_n && op_n);
endmodule

bind modem_ctl_top modem_ctl_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .unlock       (unlock),
    .rd_data      (rd_data),
    .auto_rts_en  (auto_rts_en),
    .flow_rts_req (flow_rts_req),
    .core_tx      (core_tx),
    .tx_pin       (tx_pin),
    .core_rx      (core_rx),
    .rts_n        (rts_n),
    .dtr_n        (dtr_n),
    .op_n         (op_n),
    .irq_oe       (irq_oe),
    .loop_active  (loop_active),
    .msr_hi       (msr_hi)
);

// File: tb/test_modem_ctl_top.sv
`timescale 1ns/1ps
// Self-checking bench: random and directed stimulus against a bench-side model.
module test_modem_ctl_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       unlock = 1'b0;
    logic       auto_rts_en = 1'b0;
    logic       flow_rts_req = 1'b0;
    logic       cd_n = 1'b1, ri_n = 1'b1, dsr_n = 1'b1, cts_n = 1'b1;
    logic       core_tx = 1'b1, rx_pin = 1'b1;
    logic [7:0] rd_data;
    logic       tx_pin, core_rx, rts_n, dtr_n, op_n, irq_oe;
    logic       clk_div4_sel, trig_access_en, xon_any_en, loop_active;
    logic [3:0] msr_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] m_ctl = '0;
    logic [3:0] m_s1 = 4'hF, m_s2 = 4'hF;

    modem_ctl_top i_modem_ctl_top (.*);

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_rts(input logic [7:0] c, input logic a, input logic f);
        if (c[4]) return 1'b1;
        return a ? ~f : ~c[1];
    endfunction

    function automatic logic [3:0] exp_msr(input logic [7:0] c, input logic [3:0] s);
        if (c[4]) return {c[3], c[2], c[0], c[1]};
        return ~s;
    endfunction

    // Advance one cycle, apply the edge to the model, then check every output.
    task automatic cycle();
        @(negedge clk);
        if (!rst_n) begin
            m_ctl = '0; m_s1 = 4'hF; m_s2 = 4'hF;
        end else begin
            if (wr_en) begin
                m_ctl[4:0] = wr_data[4:0];
                if (unlock) m_ctl[7:5] = wr_data[7:5];
            end
            m_s2 = m_s1;
            m_s1 = {cd_n, ri_n, dsr_n, cts_n};
        end
        chk("R1 rd_data", rd_data, m_ctl);
        chk("R2 clk_div4_sel", {7'd0, clk_div4_sel}, {7'd0, m_ctl[7]});
        chk("R3 trig_access_en", {7'd0, trig_access_en}, {7'd0, m_ctl[6]});
        chk("R3 xon_any_en", {7'd0, xon_any_en}, {7'd0, m_ctl[5]});
        chk("R4 loop_active", {7'd0, loop_active}, {7'd0, m_ctl[4]});
        chk("R4 tx_pin", {7'd0, tx_pin}, {7'd0, m_ctl[4] ? 1'b1 : core_tx});
        chk("R4 core_rx", {7'd0, core_rx}, {7'd0, m_ctl[4] ? core_tx : rx_pin});
        chk(m_ctl[4] ? "R5 msr_hi" : "R6 msr_hi", {4'd0, msr_hi}, {4'd0, exp_msr(m_ctl, m_s2)});
        chk("R7 irq_oe", {7'd0, irq_oe}, {7'd0, m_ctl[3]});
        chk(m_ctl[4] ? "R10 op_n" : "R7 op_n", {7'd0, op_n}, {7'd0, m_ctl[4] | ~m_ctl[3]});
        chk(m_ctl[4] ? "R10 rts_n" : (auto_rts_en ? "R9 rts_n" : "R8 rts_n"),
            {7'd0, rts_n}, {7'd0, exp_rts(m_ctl, auto_rts_en, flow_rts_req)});
        chk(m_ctl[4] ? "R10 dtr_n" : "R8 dtr_n", {7'd0, dtr_n}, {7'd0, m_ctl[4] | ~m_ctl[0]});
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual hung expected done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        cycle(); cycle();
        rst_n = 1'b1;
        cycle();
        chk("R11 reset register", rd_data, 8'h00);
        chk("R11 reset rts_n dtr_n", {6'd0, rts_n, dtr_n}, 8'h03);
        chk("R11 reset status", {4'd0, msr_hi}, 8'h00);
        // Directed: locked write of all ones keeps the protected field.
        wr_en = 1'b1; wr_data = 8'hFF; unlock = 1'b0; cycle();
        wr_en = 1'b0; cycle();
        chk("R1 locked write", rd_data, 8'h1F);
        wr_en = 1'b1; unlock = 1'b1; cycle();
        wr_en = 1'b0; cycle();
        chk("R1 unlocked write", rd_data, 8'hFF);
        wr_en = 1'b1; wr_data = 8'h00; unlock = 1'b0; cycle();
        wr_en = 1'b0; cycle();
        chk("R1 locked clear", rd_data, 8'hE0);
        // Directed: loop-back with DTR and OUT set.
        wr_en = 1'b1; wr_data = 8'h19; cycle();
        wr_en = 1'b0; core_tx = 1'b0; rx_pin = 1'b1; cycle();
        chk("R5 loop status", {4'd0, msr_hi}, 8'h0A);
        chk("R4 loop rx", {7'd0, core_rx}, 8'h00);
        // Random phase.
        for (int i = 0; i < 6000; i++) begin
            rst_n        = ($urandom % 500) != 0;
            wr_en        = ($urandom % 4) == 0;
            wr_data      = 8'($urandom);
            unlock       = ($urandom % 2) == 0;
            auto_rts_en  = ($urandom % 3) == 0;
            flow_rts_req = 1'($urandom);
            {cd_n, ri_n, dsr_n, cts_n} = 4'($urandom);
            core_tx      = 1'($urandom);
            rx_pin       = 1'($urandom);
            cycle();
        end
        done = 1;
        finish_run();
    end
endmodule